// File: doc/BRIEF.md
# Expansion bus slave address decoder

This block is the address phase of a slave on a 32-bit expansion bus whose upper address lines are multiplexed with data. It brings the bus address, read line, 3-bit memory-space code and the two cycle strobes into the slave clock domain. On the start of a cycle it decides whether the slave should respond. The upper address (bits 31..8) is only briefly valid, so it is captured at the moment the active-low full cycle strobe is seen to fall. The low address (bits 7..2), the read line and the space code stay valid for the whole cycle and are used directly.

Each cycle is classified as a memory access inside a programmed window, a CPU-space (interrupt) cycle, an autoconfiguration access, or nothing. Software-style configuration is modelled by a single load input that writes a base and a size mask over address bits 31..8. Autoconfiguration is recognised at two fixed upper addresses when the full strobe is used. At the older compatibility address it is also recognised when only the legacy strobe is used. A cycle started by the legacy strobe alone comes from a legacy bus master and never produces a memory or interrupt response.

Top module: `exp_slave_addr_dec`

## Requirements
- R1: While reset is low, match_mem, match_irq, match_cfg and is_read are 0, cap_addr[31:8] is 0 and no window is configured.
- R2: Every input passes through two flops. When the full strobe falls (pin high to low), outputs update on the third rising clock edge after the pin change. cap_addr[31:8] holds the upper address that was present with the strobe fall, and later changes on bus_addr_hi do not alter it. cap_addr[7:2] follows bus_addr_lo two edges late.
- R3: With the full strobe, space codes 1, 2, 5 and 6 are memory spaces, code 7 sets match_irq, and codes 0, 3 and 4 give no response of any kind. match_mem and match_irq are never both 1.
- R4: match_mem is 1 only when a window has been configured, the space code is a memory space, and (captured bits 31..8 AND mask) equals (base AND mask). Before the first cfg_load, match_mem stays 0.
- R5: is_read equals bus_read (1 = read, 0 = write) as sampled with the cycle start, and is held for the cycle.
- R6: With the full strobe and a memory space code, match_cfg is 1 when address bits 31..16 equal 16'h00E8 or 16'hFF00.
- R7: A cycle with bus_compat_n low while bus_full_n stays high sets match_cfg when address bits 23..16 equal 8'hE8 (bits 31..24 ignored) and the space is a memory space. It never sets match_mem or match_irq, even inside the configured window.
- R8: Match outputs hold while a strobe stays low. They clear on the third rising edge after both strobe pins are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slave clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr_hi | input | 24 | Multiplexed address bits 31..8 |
| bus_addr_lo | input | 6 | Address bits 7..2 |
| bus_read | input | 1 | 1 = read cycle, 0 = write |
| bus_space | input | 3 | Memory-space code |
| bus_full_n | input | 1 | Full cycle strobe, active low |
| bus_compat_n | input | 1 | Legacy compatibility strobe, active low |
| cfg_load | input | 1 | Loads base and mask, marks window configured |
| cfg_base | input | 24 | Window base, address bits 31..8 |
| cfg_mask | input | 24 | Window compare mask, address bits 31..8 |
| match_mem | output | 1 | Memory access inside window |
| match_irq | output | 1 | CPU-space cycle |
| match_cfg | output | 1 | Autoconfiguration access |
| is_read | output | 1 | Direction of current cycle |
| cap_addr | output | 30 | Captured bits 31..8 plus live bits 7..2 |

## Verification
On every cycle, the assertions check the following: memory and interrupt responses are mutually exclusive, no memory match appears before configuration, responses clear once both strobes are negated, a legacy-strobe cycle never yields a memory or interrupt response, and the upper address only changes at a cycle start. The bench's scenarios must show the rest. It sweeps all eight space codes against both read directions and addresses on and just off the window and configuration boundaries, and computes every expected flag arithmetically. It also scrambles the upper address right after the strobe to prove the capture, and it runs legacy-strobe cycles whose upper byte differs from the compatibility base.

// File: rtl/exp_slave_addr_dec.sv
module exp_slave_addr_dec #(
  parameter logic [15:0] CFG_LEGACY_BASE = 16'h00E8,
  parameter logic [15:0] CFG_FULL_BASE   = 16'hFF00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [23:0] bus_addr_hi,
  input  logic [5:0]  bus_addr_lo,
  input  logic        bus_read,
  input  logic [2:0]  bus_space,
  input  logic        bus_full_n,
  input  logic        bus_compat_n,
  input  logic        cfg_load,
  input  logic [23:0] cfg_base,
  input  logic [23:0] cfg_mask,
  output logic        match_mem,
  output logic        match_irq,
  output logic        match_cfg,
  output logic        is_read,
  output logic [29:0] cap_addr
);
  localparam int HI_W = 24;
  localparam int LO_W = 6;
  localparam int SP_W = 3;
  localparam int IW   = HI_W + LO_W + SP_W + 3;
  localparam logic [IW-1:0] SYNC_RST = {2'b11, {(IW-2){1'b0}}};

  logic [IW-1:0] sync1, sync2;
  logic [HI_W-1:0] hi_s, cap_hi, base_q, mask_q;
  logic [LO_W-1:0] lo_s;
  logic [SP_W-1:0] sp_s;
  logic rd_s, compat_s, full_s, full_q, compat_q, cfg_done;
  logic full_fall, compat_fall, mem_sp, irq_sp, win_hit, cfg_full_hit, cfg_legacy_hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= SYNC_RST;
      sync2 <= SYNC_RST;
    end else begin
      sync1 <= {bus_full_n, bus_compat_n, bus_read, bus_space, bus_addr_lo, bus_addr_hi};
      sync2 <= sync1;
    end

  assign hi_s     = sync2[HI_W-1:0];
  assign lo_s     = sync2[HI_W +: LO_W];
  assign sp_s     = sync2[HI_W+LO_W +: SP_W];
  assign rd_s     = sync2[IW-3];
  assign compat_s = sync2[IW-2];
  assign full_s   = sync2[IW-1];

  assign full_fall   = full_q & ~full_s;
  assign compat_fall = compat_q & ~compat_s & full_s;

  assign mem_sp = (sp_s == 3'd1) || (sp_s == 3'd2) || (sp_s == 3'd5) || (sp_s == 3'd6);
  assign irq_sp = (sp_s == 3'd7);
  assign win_hit = cfg_done && mem_sp && ((hi_s & mask_q) == (base_q & mask_q));
  assign cfg_full_hit = mem_sp &&
    ((hi_s[HI_W-1:8] == CFG_LEGACY_BASE) || (hi_s[HI_W-1:8] == CFG_FULL_BASE));
  assign cfg_legacy_hit = mem_sp && (hi_s[15:8] == CFG_LEGACY_BASE[7:0]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      base_q   <= '0;
      mask_q   <= '0;
      cfg_done <= 1'b0;
    end else if (cfg_load) begin
      base_q   <= cfg_base;
      mask_q   <= cfg_mask;
      cfg_done <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      full_q    <= 1'b1;
      compat_q  <= 1'b1;
      cap_hi    <= '0;
      match_mem <= 1'b0;
      match_irq <= 1'b0;
      match_cfg <= 1'b0;
      is_read   <= 1'b0;
    end else begin
      full_q   <= full_s;
      compat_q <= compat_s;
      if (full_fall) begin
        cap_hi    <= hi_s;
        match_mem <= win_hit;
        match_irq <= irq_sp;
        match_cfg <= cfg_full_hit;
        is_read   <= rd_s;
      end else if (compat_fall) begin
        cap_hi    <= hi_s;
        match_mem <= 1'b0;
        match_irq <= 1'b0;
        match_cfg <= cfg_legacy_hit;
        is_read   <= rd_s;
      end else if (full_s && compat_s) begin
        match_mem <= 1'b0;
        match_irq <= 1'b0;
        match_cfg <= 1'b0;
      end
    end

  assign cap_addr = {cap_hi, lo_s};

  p_mem_irq_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(match_mem && match_irq));
  p_no_mem_unconfigured_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_done |-> !match_mem);
  p_clear_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (full_s && compat_s) |=> (!match_mem && !match_irq && !match_cfg));
  p_legacy_no_mem_r7: assert property (@(posedge clk) disable iff (!rst_n)
    compat_fall |=> (!match_mem && !match_irq));
  p_cap_at_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_hi) |-> $past(full_fall || compat_fall));
  p_irq_from_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_irq) |-> $past(full_fall));
endmodule

// File: tb/exp_slave_addr_dec_tb.sv
module exp_slave_addr_dec_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [23:0] bus_addr_hi = '0;
  logic [5:0]  bus_addr_lo = '0;
  logic        bus_read = 1'b0;
  logic [2:0]  bus_space = '0;
  logic        bus_full_n = 1'b1;
  logic        bus_compat_n = 1'b1;
  logic        cfg_load = 1'b0;
  logic [23:0] cfg_base = '0;
  logic [23:0] cfg_mask = '0;
  logic match_mem, match_irq, match_cfg, is_read;
  logic [29:0] cap_addr;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit cfgd = 0;
  logic [23:0] w_base = 24'h400000;
  logic [23:0] w_mask = 24'hFFF000;

  always #2.5 clk = ~clk;

  exp_slave_addr_dec dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr_hi(bus_addr_hi), .bus_addr_lo(bus_addr_lo),
    .bus_read(bus_read), .bus_space(bus_space), .bus_full_n(bus_full_n),
    .bus_compat_n(bus_compat_n), .cfg_load(cfg_load), .cfg_base(cfg_base),
    .cfg_mask(cfg_mask), .match_mem(match_mem), .match_irq(match_irq),
    .match_cfg(match_cfg), .is_read(is_read), .cap_addr(cap_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit is_mem(input logic [2:0] sp);
    return sp == 3'd1 || sp == 3'd2 || sp == 3'd5 || sp == 3'd6;
  endfunction

  task automatic full_cycle(input logic [23:0] hi, input logic [5:0] lo,
                            input logic rd, input logic [2:0] sp);
    logic em, ei, ec;
    em = cfgd && is_mem(sp) && ((hi & w_mask) == (w_base & w_mask));
    ei = (sp == 3'd7);
    ec = is_mem(sp) && (hi[23:8] == 16'h00E8 || hi[23:8] == 16'hFF00);
    @(negedge clk);
    bus_addr_hi = hi; bus_addr_lo = lo; bus_read = rd; bus_space = sp;
    @(negedge clk);
    bus_full_n = 1'b0;
    @(negedge clk);
    bus_addr_hi = ~hi;
    repeat (3) @(negedge clk);
    chk("R4 match_mem", {31'd0, match_mem}, {31'd0, em});
    chk("R3 match_irq", {31'd0, match_irq}, {31'd0, ei});
    chk("R6 match_cfg", {31'd0, match_cfg}, {31'd0, ec});
    chk("R5 is_read", {31'd0, is_read}, {31'd0, rd});
    chk("R2 cap_addr", {2'd0, cap_addr}, {2'd0, hi, lo});
    bus_full_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 cleared", {29'd0, match_mem, match_irq, match_cfg}, 32'd0);
  endtask

  task automatic legacy_cycle(input logic [23:0] hi, input logic [2:0] sp);
    logic ec;
    ec = is_mem(sp) && (hi[15:8] == 8'hE8);
    @(negedge clk);
    bus_addr_hi = hi; bus_addr_lo = 6'h15; bus_read = 1'b1; bus_space = sp;
    @(negedge clk);
    bus_compat_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7 legacy cfg", {31'd0, match_cfg}, {31'd0, ec});
    chk("R7 legacy no mem/irq", {30'd0, match_mem, match_irq}, 32'd0);
    bus_compat_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 legacy cleared", {31'd0, match_cfg}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {28'd0, match_mem, match_irq, match_cfg, is_read}, 32'd0);
    chk("R1 reset cap_addr", {8'd0, cap_addr[29:6]}, 32'd0);
    rst_n = 1'b1;
    for (int s = 0; s < 8; s++) begin
      full_cycle(24'h400000, 6'h01, 1'b1, s[2:0]);
      full_cycle(24'h00E812, 6'h3F, 1'b0, s[2:0]);
    end
    @(negedge clk);
    cfg_base = w_base; cfg_mask = w_mask; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0; cfgd = 1;
    for (int a = 0; a < 7; a++) begin
      logic [23:0] hi;
      case (a)
        0: hi = 24'h400000;
        1: hi = 24'h400FFF;
        2: hi = 24'h401000;
        3: hi = 24'h3FFFFF;
        4: hi = 24'h00E800;
        5: hi = 24'hFF0034;
        default: hi = 24'h00E900;
      endcase
      for (int s = 0; s < 8; s++)
        for (int r = 0; r < 2; r++)
          full_cycle(hi, 6'(a * 9 + s), r[0], s[2:0]);
    end
    for (int s = 0; s < 8; s++) begin
      legacy_cycle(24'h00E800, s[2:0]);
      legacy_cycle(24'h5AE8C3, s[2:0]);
      legacy_cycle(24'h00E900, s[2:0]);
      legacy_cycle(24'h400000, s[2:0]);
    end
    @(negedge clk);
    bus_addr_lo = 6'h2A;
    repeat (3) @(negedge clk);
    chk("R2 live low address", {26'd0, cap_addr[5:0]}, 32'h2A);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule